// File: doc/BRIEF.md
# DRAM Page-Mode Wait-State Controller

This block sits between a fast processor bus and a page-mode DRAM module whose storage is arranged as 4-byte cells in rows and columns. For every bus access it decides how long the access must be stretched. It keeps one open row and one current cell. It recognises a repeat of the current cell and a step to the next cell. It runs a periodic refresh that closes the open row. A done strobe ends each access, and the decoded row and column are presented on their own outputs.

The block runs on a clock at twice the processor rate, so one clock equals half a processor cycle and fractional costs such as 3.5 cycles become whole counts (7 clocks). A request is a single-cycle strobe issued while the block is idle. The next request follows only after done. A five-entry module-type code selects how the word address is divided into row and column fields.

Top module: `dram_wait_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, done and refreshActive are 0, rowAddr and colAddr are 0, and no row is open.
- R2: Let L be the cost of a request in clocks, and let req be sampled high at rising edge k. Then done is high for exactly one clock, the clock after edge k+L-1. A read of the current cell, or of the cell whose column index is the current column plus one in the open row, costs L=2. There is no wrap past the last column of a row.
- R3: A read of any other cell in the open row costs L=4.
- R4: A read when no row is open or in a different row costs L=7. This includes the first access after reset.
- R5: A write into the open row costs L=2 for any column. A write when no row is open or in a different row costs L=6.
- R6: Byte address bits [1:0] select a byte within a cell and are ignored. The column is the C bits starting at bit 2. The row is the R bits just above the column. Address bits above bit 2+C+R are ignored. Both fields are zero-extended onto rowAddr (12 bits) and colAddr (11 bits) when the access starts.
- R7: simmType gives R/C as follows: 0 gives 9/9, 1 gives 10/10, 2 gives 11/10, 3 gives 12/10 and 4 gives 11/11. Codes 5, 6 and 7 decode exactly like code 0.
- R8: Every access, read or write, makes its cell the current cell. Going back to an earlier cell in the same row therefore costs L=4 for a read.
- R9: A refresh falls due at rising edges 400, 800, 1200 and so on, counted from the first edge after reset release. If the block is idle at that edge, refreshActive is high for the 10 clocks that follow.
- R10: A request sampled while a refresh is starting or running is held. It starts on the edge that ends the refresh and pays the closed-row cost. A read sampled on the refresh's first edge therefore costs L=17, and a write costs L=16. A request sampled j edges later costs j fewer clocks.
- R11: A refresh that falls due during an access is held pending. It starts on the edge after done's edge. At most one refresh is pending at a time.
- R12: After a refresh no row is open, so the next access pays the new-row cost even when it addresses the row that was open before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate (one clock = half cycle) |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Single-cycle access request |
| wrEn | input | 1 | 1 = write, 0 = read, sampled with req |
| byteAddr | input | 24 | Byte address, sampled with req |
| simmType | input | 3 | Module geometry code, sampled with req |
| done | output | 1 | One-cycle strobe ending the access |
| rowAddr | output | 12 | Row index presented for the current access |
| colAddr | output | 11 | Column (cell) index presented for the current access |
| refreshActive | output | 1 | High while a refresh runs |

## Verification
The access sequences move within one cell, step to the next cell, jump to a distant cell in the same row and jump to another row, for reads and for writes. Each cost class therefore shows up as its own latency. Returning to an earlier cell tells a single tracked cell apart from any cell history. Geometry codes are tried with addresses whose row and column differ between codes, so a wrong field split or a wrong fallback for codes 5 to 7 changes both the latency and the presented indices. Refresh is met at its first edge and part-way through. It is also met during an access, and before an access to the row that was open, which separates held requests, deferred refresh and the closing of the row.

// File: rtl/dram_wait_pkg.sv
package dram_wait_pkg;

  localparam int NUM_TYPES = 5;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_REFRESH = 2'd2
  } ctlState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic hold;      // capture the live request for later
    logic commit;    // start an access: open its row, make its cell current
    logic useHeld;   // classify the held request instead of the live one
    logic closeRow;  // refresh starts: forget the open row
  } dpStrobe_t;

  function automatic int colBitsOf(int t);
    case (t)
      1, 2, 3: return 10;
      4:       return 11;
      default: return 9;
    endcase
  endfunction

  function automatic int rowBitsOf(int t);
    case (t)
      1:       return 10;
      2, 4:    return 11;
      3:       return 12;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/dram_wait_dp.sv
module dram_wait_dp
  import dram_wait_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 11,
  parameter int COST_W     = 5,
  parameter int HIT_HALF   = 2,
  parameter int CELL_HALF  = 4,
  parameter int ROWRD_HALF = 7,
  parameter int ROWWR_HALF = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [ADDR_W-3:0]  liveWordAddr,
  input  logic               liveWe,
  input  logic [2:0]         liveType,
  output logic [COST_W-1:0]  cost,
  output logic [ROW_W-1:0]   rowAddr,
  output logic [COL_W-1:0]   colAddr
);

  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]  heldAddr, selAddr;
  logic             heldWe, selWe;
  logic [2:0]       heldType, selType, effType;
  logic [ROW_W-1:0] openRow, rowSel;
  logic [COL_W-1:0] lastCol, colSel;
  logic [COL_W:0]   nextCol;
  logic             rowValid, sameRow, nearCell;
  logic [ROW_W-1:0] rowCand [NUM_TYPES];
  logic [COL_W-1:0] colCand [NUM_TYPES];

  assign selAddr = strobe.useHeld ? heldAddr : liveWordAddr;
  assign selWe   = strobe.useHeld ? heldWe   : liveWe;
  assign selType = strobe.useHeld ? heldType : liveType;
  assign effType = (selType < 3'(NUM_TYPES)) ? selType : 3'd0;

  // One field split per module geometry.
  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_geom
    localparam int CB = colBitsOf(g);
    localparam int RB = rowBitsOf(g);
    assign colCand[g] = COL_W'(selAddr[CB-1:0]);
    assign rowCand[g] = ROW_W'(selAddr[CB +: RB]);
  end

  always_comb begin
    rowSel = rowCand[0];
    colSel = colCand[0];
    for (int i = 1; i < NUM_TYPES; i++) begin
      if (effType == 3'(i)) begin
        rowSel = rowCand[i];
        colSel = colCand[i];
      end
    end
  end

  assign nextCol  = {1'b0, lastCol} + 1'b1;
  assign sameRow  = rowValid && (rowSel == openRow);
  assign nearCell = (colSel == lastCol) || ({1'b0, colSel} == nextCol);

  always_comb begin
    if (!sameRow)      cost = selWe ? COST_W'(ROWWR_HALF) : COST_W'(ROWRD_HALF);
    else if (selWe)    cost = COST_W'(HIT_HALF);
    else if (nearCell) cost = COST_W'(HIT_HALF);
    else               cost = COST_W'(CELL_HALF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldWe   <= 1'b0;
      heldType <= '0;
      openRow  <= '0;
      lastCol  <= '0;
      rowValid <= 1'b0;
      rowAddr  <= '0;
      colAddr  <= '0;
    end else begin
      if (strobe.hold) begin
        heldAddr <= liveWordAddr;
        heldWe   <= liveWe;
        heldType <= liveType;
      end
      if (strobe.closeRow) begin
        rowValid <= 1'b0;
      end else if (strobe.commit) begin
        openRow  <= rowSel;
        lastCol  <= colSel;
        rowValid <= 1'b1;
        rowAddr  <= rowSel;
        colAddr  <= colSel;
      end
    end
  end

  // R12: a refresh start leaves no row open in the next cycle.
  p_row_closed_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.closeRow |=> !rowValid);

  // R10: an access never starts on the edge that starts a refresh.
  p_no_start_on_close_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.closeRow |-> !strobe.commit);

endmodule

// File: rtl/dram_wait_fsm.sv
module dram_wait_fsm
  import dram_wait_pkg::*;
#(
  parameter int REF_PERIOD = 400,
  parameter int REF_HALF   = 10,
  parameter int COST_W     = 5,
  parameter int MAX_COST   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [COST_W-1:0] cost,
  output dpStrobe_t         strobe,
  output logic              done,
  output logic              refreshActive
);

  localparam int PER_W = $clog2(REF_PERIOD);
  localparam int RC_W  = $clog2(REF_HALF);
  localparam int RUN_W = $clog2(REF_HALF + 1) + 1;

  ctlState_t         state;
  logic [COST_W-1:0] waitCnt;
  logic [RC_W-1:0]   refCnt;
  logic [PER_W-1:0]  refCount;
  logic              refPend, heldValid, tick, refDue;

  assign tick          = (refCount == PER_W'(REF_PERIOD - 1));
  assign refDue        = tick || refPend;
  assign refreshActive = (state == ST_REFRESH);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: begin
        if (refDue) begin
          strobe.closeRow = 1'b1;
          strobe.hold     = req;
        end else begin
          strobe.commit = req;
        end
      end
      ST_REFRESH: begin
        if (refCnt != '0) begin
          strobe.hold = req && !heldValid;
        end else begin
          strobe.commit  = heldValid || req;
          strobe.useHeld = heldValid;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      refCnt    <= '0;
      refCount  <= '0;
      refPend   <= 1'b0;
      heldValid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done     <= 1'b0;
      refCount <= tick ? '0 : refCount + 1'b1;
      if (tick) refPend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (strobe.closeRow) begin
            state   <= ST_REFRESH;
            refCnt  <= RC_W'(REF_HALF - 1);
            refPend <= 1'b0;
            if (strobe.hold) heldValid <= 1'b1;
          end else if (strobe.commit) begin
            state   <= ST_ACCESS;
            waitCnt <= cost - COST_W'(2);
          end
        end
        ST_ACCESS: begin
          if (waitCnt == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_REFRESH: begin
          if (refCnt != '0) begin
            refCnt <= refCnt - 1'b1;
            if (strobe.hold) heldValid <= 1'b1;
          end else if (strobe.commit) begin
            state     <= ST_ACCESS;
            waitCnt   <= cost - COST_W'(2);
            heldValid <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Length of the current refresh run, kept for the check below.
  logic [RUN_W-1:0] refRunLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refRunLen <= '0;
    else if (refreshActive) refRunLen <= refRunLen + 1'b1;
    else                    refRunLen <= '0;
  end

  // R2: done is a single-cycle strobe.
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: every refresh lasts exactly REF_HALF clocks.
  p_refresh_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refreshActive) |-> (refRunLen == RUN_W'(REF_HALF)));

  // R10: no access completes while a refresh runs.
  p_no_done_in_refresh_r10: assert property (@(posedge clk) disable iff (!rstN)
    refreshActive |-> !done);

  // R11: a pending refresh starts right after the access that delayed it.
  p_pending_served_r11: assert property (@(posedge clk) disable iff (!rstN)
    (done && refPend) |=> refreshActive);

  // R4: the wait count never exceeds the largest access cost.
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACCESS) |-> (waitCnt <= COST_W'(MAX_COST - 2)));

endmodule

// File: rtl/dram_wait_ctrl.sv
module dram_wait_ctrl
  import dram_wait_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 11,
  parameter int HIT_HALF   = 2,
  parameter int CELL_HALF  = 4,
  parameter int ROWRD_HALF = 7,
  parameter int ROWWR_HALF = 6,
  parameter int REF_HALF   = 10,
  parameter int REF_PERIOD = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [2:0]        simmType,
  output logic              done,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              refreshActive
);

  localparam int MAX_A    = (HIT_HALF > CELL_HALF) ? HIT_HALF : CELL_HALF;
  localparam int MAX_B    = (ROWRD_HALF > ROWWR_HALF) ? ROWRD_HALF : ROWWR_HALF;
  localparam int MAX_COST = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int COST_W   = $clog2(MAX_COST + 1);

  dpStrobe_t         strobe;
  logic [COST_W-1:0] cost;

  // Byte-within-cell bits do not take part in timing.
  logic unusedByteSel;
  assign unusedByteSel = ^byteAddr[1:0];

  dram_wait_fsm #(
    .REF_PERIOD (REF_PERIOD),
    .REF_HALF   (REF_HALF),
    .COST_W     (COST_W),
    .MAX_COST   (MAX_COST)
  ) u_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .req           (req),
    .cost          (cost),
    .strobe        (strobe),
    .done          (done),
    .refreshActive (refreshActive)
  );

  dram_wait_dp #(
    .ADDR_W     (ADDR_W),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .COST_W     (COST_W),
    .HIT_HALF   (HIT_HALF),
    .CELL_HALF  (CELL_HALF),
    .ROWRD_HALF (ROWRD_HALF),
    .ROWWR_HALF (ROWWR_HALF)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .liveWordAddr (byteAddr[ADDR_W-1:2]),
    .liveWe       (wrEn),
    .liveType     (simmType),
    .cost         (cost),
    .rowAddr      (rowAddr),
    .colAddr      (colAddr)
  );

endmodule

// File: tb/sim_dram_wait_ctrl.sv
`timescale 1ns/1ps
module sim_dram_wait_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        wrEn = 1'b0;
  logic [23:0] byteAddr = '0;
  logic [2:0]  simmType = '0;
  logic        done, refreshActive;
  logic [11:0] rowAddr;
  logic [10:0] colAddr;

  dram_wait_ctrl u0 (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .byteAddr(byteAddr),
    .simmType(simmType), .done(done), .rowAddr(rowAddr), .colAddr(colAddr),
    .refreshActive(refreshActive)
  );

  always #4 clk = ~clk;  // 125 MHz

  int edgeNo = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always @(posedge clk) if (rstN) edgeNo <= edgeNo + 1;

  typedef struct {
    int    driveEdge;
    int    expEdge;
    int    row;
    int    col;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Geometry from the requirement table (R6, R7).
  function automatic void geom(input logic [2:0] t, output int rb, output int cb);
    case (t)
      3'd1: begin rb = 10; cb = 10; end
      3'd2: begin rb = 11; cb = 10; end
      3'd3: begin rb = 12; cb = 10; end
      3'd4: begin rb = 11; cb = 11; end
      default: begin rb = 9; cb = 9; end
    endcase
  endfunction

  task automatic waitEdge(int n);
    while (edgeNo < n) @(negedge clk);
  endtask

  // Driver: call at a negedge; pushes the expected result, pulses req.
  task automatic access(input logic w, input logic [23:0] a, input logic [2:0] t,
                        input int lat, input string tag);
    exp_t it;
    int rb, cb;
    geom(t, rb, cb);
    it.driveEdge = edgeNo;
    it.expEdge   = edgeNo + lat;
    it.col       = int'(a >> 2) & ((1 << cb) - 1);
    it.row       = int'(a >> (2 + cb)) & ((1 << rb) - 1);
    it.tag       = tag;
    q.push_back(it);
    req = 1'b1; wrEn = w; byteAddr = a; simmType = t;
    @(negedge clk);
    req = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compares done timing and presented indices.
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          check(edgeNo == it.expEdge, it.tag, "latency",
                edgeNo - it.driveEdge, it.expEdge - it.driveEdge);
          check(int'(rowAddr) == it.row && int'(colAddr) == it.col, it.tag,
                "row*4096+col", int'(rowAddr) * 4096 + int'(colAddr),
                it.row * 4096 + it.col);
        end
      end else if (q.size() != 0 && edgeNo > q[0].expEdge) begin
        exp_t it;
        it = q.pop_front();
        check(1'b0, it.tag, "latency (no done in time)",
              edgeNo - it.driveEdge, it.expEdge - it.driveEdge);
      end
    end
  end

  task automatic refCheck(int n, logic expv, string tag);
    waitEdge(n);
    check(refreshActive == expv, tag, $sformatf("refreshActive at edge %0d", n),
          int'(refreshActive), int'(expv));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && refreshActive == 1'b0, "R1", "done|refresh in reset",
          int'(done) + int'(refreshActive), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && refreshActive == 1'b0, "R1", "done|refresh after reset",
          int'(done) + int'(refreshActive), 0);
    check(rowAddr == '0 && colAddr == '0, "R1", "indices after reset",
          int'(rowAddr) + int'(colAddr), 0);

    // Cost classes, geometry code 3 (12/10).
    access(1'b0, 24'h020000, 3'd3, 7, "R4");  // first access: new row
    access(1'b0, 24'h020001, 3'd3, 2, "R2");  // same cell
    access(1'b0, 24'h020004, 3'd3, 2, "R2");  // next cell
    access(1'b0, 24'h020100, 3'd3, 4, "R3");  // distant cell, same row
    access(1'b0, 24'h020008, 3'd3, 4, "R8");  // back to an earlier cell
    access(1'b1, 24'h030000, 3'd3, 6, "R5");  // write, new row
    access(1'b1, 24'h030400, 3'd3, 2, "R5");  // write, same row, distant cell
    access(1'b0, 24'h030404, 3'd3, 2, "R8");  // read after write: write set the cell
    access(1'b0, 24'h020000, 3'd3, 7, "R4");  // read, row change

    // Geometry codes.
    access(1'b0, 24'h123456, 3'd4, 7, "R7");
    access(1'b0, 24'hFF1234, 3'd0, 7, "R7");
    access(1'b0, 24'hFF1238, 3'd5, 2, "R7");  // code 5 acts as code 0
    access(1'b0, 24'h0F1234, 3'd0, 4, "R6");  // high bits ignored, column back by one
    access(1'b0, 24'h7FFFFC, 3'd2, 7, "R6");
    access(1'b1, 24'h3FF000, 3'd1, 6, "R5");
    access(1'b1, 24'h3FF010, 3'd1, 2, "R5");

    // Read sampled on the first refresh edge: worst case.
    waitEdge(399);
    fork
      access(1'b0, 24'h020000, 3'd3, 17, "R10");
      begin
        refCheck(399, 1'b0, "R9");
        refCheck(400, 1'b1, "R9");
        refCheck(409, 1'b1, "R9");
        refCheck(410, 1'b0, "R9");
      end
    join
    access(1'b0, 24'h020004, 3'd3, 2, "R2");

    // Read sampled part-way through a refresh.
    waitEdge(803);
    access(1'b0, 24'h020008, 3'd3, 13, "R10");

    // Write sampled on the first refresh edge.
    waitEdge(1199);
    access(1'b1, 24'h020000, 3'd3, 16, "R10");
    access(1'b0, 24'h020004, 3'd3, 2, "R2");
    waitEdge(1500);
    access(1'b0, 24'h020008, 3'd3, 2, "R2");

    // Refresh while idle closes the row.
    waitEdge(1620);
    check(refreshActive == 1'b0, "R12", "refreshActive before access",
          int'(refreshActive), 0);
    access(1'b0, 24'h02000C, 3'd3, 7, "R12");

    // Refresh falling due during an access is deferred.
    waitEdge(1996);
    fork
      access(1'b0, 24'h030000, 3'd3, 7, "R11");
      begin
        refCheck(2001, 1'b0, "R11");
        refCheck(2003, 1'b0, "R11");
        refCheck(2004, 1'b1, "R11");
        refCheck(2013, 1'b1, "R11");
        refCheck(2014, 1'b0, "R11");
      end
    join
    access(1'b0, 24'h030000, 3'd3, 7, "R12");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (6000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 6000);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule